// File: doc/BRIEF.md
# GF(2^8) Sequential Divider by Fermat Inversion

This block divides one 8-bit Galois field element by another, as needed when a Reed-Solomon decoder turns error-evaluator and locator-derivative values into error magnitudes. It has no inverse table and no dedicated inverter. It raises the divisor to the power 254, which is the inverse of any nonzero element because every nonzero element of GF(2^8) satisfies x^255 = 1. It then multiplies that inverse by the dividend.

A single combinational GF multiplier is stepped through a fixed schedule of twelve products, one per clock. The first eleven follow the exponent chain 1, 2, 3, 6, 12, 24, 30, 31, 62, 124, 127, 254. The twelfth multiplies by the dividend. Two intermediate powers, x^3 and x^6, are kept beside the running value. A caller pulses `start` with the operands, waits for the one-cycle `done` pulse, and reads the quotient and a divide-by-zero flag. These stay valid until the next completion.

Top module: `gf_div_exp`

## Requirements
- R1: For a nonzero divisor b and any dividend a, the quotient equals the product a * b^-1 in GF(2^8), with field polynomial x^8+x^4+x^3+x^2+1 (0x11D).
- R2: A zero dividend with a nonzero divisor gives a quotient of 0x00, and the divide-by-zero flag is low.
- R3: A zero divisor gives a quotient of 0x00 with the divide-by-zero flag high, whatever the dividend.
- R4: A `start` sampled while `busy` is low is accepted. `busy` is high from the next cycle for exactly 13 cycles. `done` is a one-cycle pulse in the cycle after `busy` falls, 13 clock edges after the accepting edge.
- R5: `start` and operand changes while `busy` is high are ignored. The running division completes on its original schedule, with the quotient of its original operands.
- R6: While reset is high and after it, until the first accepted start, `busy`, `done`, `quotient` and `div_zero` are all zero.
- R7: `quotient` and `div_zero` change only in the cycle in which `done` is high, and they hold their value in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a division, sampled when not busy |
| dividend | input | 8 | Numerator a |
| divisor | input | 8 | Denominator b |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 8 | Registered a / b, held between completions |
| div_zero | output | 1 | Registered flag: last divisor was zero |

## Verification
The assertions assume that `start` is a synchronous level, sampled only on the rising edge, and that reset is held for at least one edge before the first request. The bench drives every input on the falling edge and holds reset for several cycles, so these assumptions hold. The assertions do not require `start` to be dropped after it is accepted. The bench deliberately raises it again, with other operands, while a division is running, to show that the request is ignored.

// File: rtl/gf_div_pkg.sv
package gf_div_pkg;
  localparam int NUM_STEPS = 12;
  localparam int STEP_W    = 4;

  typedef enum logic [2:0] {
    OPB_RUN,
    OPB_BASE,
    OPB_P3,
    OPB_P6,
    OPB_NUM
  } opb_sel_e;

  // Second operand for each schedule step; the first operand is always the running value.
  function automatic opb_sel_e step_operand(input logic [STEP_W-1:0] step);
    case (step)
      4'd0, 4'd1, 4'd6: step_operand = OPB_BASE;
      4'd5:             step_operand = OPB_P6;
      4'd9:             step_operand = OPB_P3;
      4'd11:            step_operand = OPB_NUM;
      default:          step_operand = OPB_RUN;
    endcase
  endfunction
endpackage

// File: rtl/gf_mul.sv
module gf_mul #(
  parameter int          W    = 8,
  parameter logic [W:0]  POLY = 9'h11D
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p
);
  logic [W-1:0] shifted [W];
  logic [W-1:0] partial [W+1];

  assign shifted[0] = a;
  assign partial[0] = '0;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign partial[i+1] = partial[i] ^ (b[i] ? shifted[i] : '0);
      if (i < W-1) begin : g_shift
        assign shifted[i+1] = {shifted[i][W-2:0], 1'b0} ^
                              (shifted[i][W-1] ? POLY[W-1:0] : '0);
      end
    end
  endgenerate

  assign p = partial[W];
endmodule

// File: rtl/gf_div_ctrl.sv
module gf_div_ctrl
  import gf_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              load,
  output logic              mul_en,
  output logic              finish,
  output logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_STEPS);

  logic [STEP_W-1:0] cnt;

  assign load   = start && !busy;
  assign mul_en = busy && (cnt != LAST);
  assign finish = busy && (cnt == LAST);
  assign step   = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end
  end
endmodule

// File: rtl/gf_div_dp.sv
module gf_div_dp
  import gf_div_pkg::*;
#(
  parameter int          W    = 8,
  parameter logic [W:0]  POLY = 9'h11D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              mul_en,
  input  logic              finish,
  input  logic [STEP_W-1:0] step,
  input  logic [W-1:0]      num_in,
  input  logic [W-1:0]      den_in,
  output logic              done,
  output logic [W-1:0]      quotient,
  output logic              div_zero
);
  logic [W-1:0] base_q, num_q, run_q, p3_q, p6_q;
  logic [W-1:0] opb, prod;

  always_comb begin
    case (step_operand(step))
      OPB_BASE: opb = base_q;
      OPB_P3:   opb = p3_q;
      OPB_P6:   opb = p6_q;
      OPB_NUM:  opb = num_q;
      default:  opb = run_q;
    endcase
  end

  gf_mul #(.W(W), .POLY(POLY)) u_mul (
    .a(run_q),
    .b(opb),
    .p(prod)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      num_q  <= '0;
      run_q  <= '0;
      p3_q   <= '0;
      p6_q   <= '0;
    end else if (load) begin
      base_q <= den_in;
      num_q  <= num_in;
      run_q  <= den_in;
    end else if (mul_en) begin
      run_q <= prod;
      if (step == STEP_W'(1)) p3_q <= prod;
      if (step == STEP_W'(2)) p6_q <= prod;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      quotient <= '0;
      div_zero <= 1'b0;
    end else begin
      done <= finish;
      if (finish) begin
        quotient <= (base_q == '0) ? '0 : run_q;
        div_zero <= (base_q == '0);
      end
    end
  end
endmodule

// File: rtl/gf_div_exp.sv
module gf_div_exp
  import gf_div_pkg::*;
#(
  parameter int          W    = 8,
  parameter logic [W:0]  POLY = 9'h11D
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic         div_zero
);
  logic              load, mul_en, finish;
  logic [STEP_W-1:0] step;

  gf_div_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .load(load), .mul_en(mul_en),
    .finish(finish), .step(step)
  );

  gf_div_dp #(.W(W), .POLY(POLY)) u_dp (
    .clk(clk), .rst(rst), .load(load), .mul_en(mul_en),
    .finish(finish), .step(step),
    .num_in(dividend), .den_in(divisor),
    .done(done), .quotient(quotient), .div_zero(div_zero)
  );
endmodule

// File: rtl/gf_div_exp_chk.sv
module gf_div_exp_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic         div_zero
);
  logic [4:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  a_r4_busy_follows_start: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r4_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_cnt == 5'd13));

  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r4_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r5_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && !$fell(busy)) |=> (busy || done));

  a_r3_zero_quotient: assert property (@(posedge clk) disable iff (rst)
    (done && div_zero) |-> (quotient == '0));

  a_r7_hold_q: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(quotient) && $stable(div_zero)));
endmodule

bind gf_div_exp gf_div_exp_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .quotient(quotient), .div_zero(div_zero)
);

// File: tb/gf_div_exp_bench.sv
`timescale 1ns/1ps
module gf_div_exp_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] dividend = '0;
  logic [7:0] divisor = '0;
  logic       busy, done, div_zero;
  logic [7:0] quotient;

  always #2 clk = ~clk;

  gf_div_exp u_gf_div_exp (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .div_zero(div_zero)
  );

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  string tag = "R6";

  // Reference arithmetic: carry-less product, then reduction from the top bit down.
  function automatic int ref_mul(input int a, input int b);
    int acc = 0;
    for (int i = 0; i < 8; i++) if ((b >> i) & 1) acc = acc ^ (a << i);
    for (int k = 14; k >= 8; k--) if ((acc >> k) & 1) acc = acc ^ (32'h11D << (k - 8));
    return acc & 8'hFF;
  endfunction

  function automatic int ref_div(input int a, input int b);
    if (b == 0) return 0;
    for (int y = 1; y < 256; y++)
      if (ref_mul(b, y) == 1) return ref_mul(a, y);
    return -1;
  endfunction

  // Cycle model
  int m_busy = 0, m_done = 0, m_q = 0, m_dz = 0, m_cnt = 0, m_a = 0, m_b = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_q = 0; m_dz = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_busy != 0) begin
        m_cnt++;
        if (m_cnt == 13) begin
          m_busy = 0;
          m_done = 1;
          m_q  = ref_div(m_a, m_b);
          m_dz = (m_b == 0) ? 1 : 0;
        end
      end else if (start) begin
        m_busy = 1; m_cnt = 0;
        m_a = int'(dividend); m_b = int'(divisor);
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    vectors++;
    if (int'(busy) != m_busy || int'(done) != m_done) begin
      miscompares++;
      $display("FAIL %s handshake (R4): busy=%0d done=%0d expected busy=%0d done=%0d",
               (tag == "R6") ? "R6" : "R4", busy, done, m_busy, m_done);
    end
    if (int'(quotient) != m_q || int'(div_zero) != m_dz) begin
      miscompares++;
      $display("FAIL %s result: q=%02h dz=%0d expected q=%02h dz=%0d",
               tag, quotient, div_zero, m_q[7:0], m_dz);
    end
  end

  task automatic run_div(input int a, input int b, input string t);
    @(negedge clk);
    tag = t;
    dividend = 8'(a); divisor = 8'(b); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (14) @(negedge clk);
    tag = "R7";
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);      // R6: idle zeros after reset
    run_div(8'h01, 8'h01, "R1");
    run_div(8'h53, 8'hCA, "R1");
    run_div(8'hFF, 8'h02, "R1");
    run_div(8'h80, 8'hFF, "R1");
    run_div(8'h9A, 8'h9A, "R1");
    for (int n = 0; n < 40; n++) run_div(int'($urandom_range(0, 255)), int'($urandom_range(1, 255)), "R1");
    run_div(8'h00, 8'h37, "R2");
    run_div(8'h00, 8'hFF, "R2");
    run_div(8'h55, 8'h00, "R3");
    run_div(8'h00, 8'h00, "R3");
    run_div(8'h12, 8'h34, "R1");    // leaves nonzero result before zero divisor
    run_div(8'hC3, 8'h00, "R3");
    // R5: restart attempts while busy
    @(negedge clk);
    tag = "R5";
    dividend = 8'h6B; divisor = 8'h1D; start = 1'b1;
    @(negedge clk);
    dividend = 8'h00; divisor = 8'h00;
    repeat (4) @(negedge clk);
    start = 1'b0; dividend = 8'hEE; divisor = 8'h01;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    tag = "R7";
    repeat (3) @(negedge clk);
    // back-to-back requests with start held high
    tag = "R4";
    dividend = 8'h21; divisor = 8'h42; start = 1'b1;
    repeat (30) @(negedge clk);
    start = 1'b0;
    repeat (16) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(negedge clk) begin
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule